// File: doc/BRIEF.md
# Receive descriptor ring engine

This block stores incoming frames in host memory by walking a ring of receive descriptors. The host lays the ring out in a word-addressed memory, gives the block the word address of the first descriptor, and sets a run bit. While running, the block keeps re-reading the descriptor it points at. When a frame starts it takes that descriptor only if the device owns it. It then writes the frame bytes into the buffer the descriptor names. Last, it writes back a status word that carries the frame length and an error summary, and that hands the descriptor back to the host.

A descriptor is four consecutive 32-bit words. Word +0 is the status word, word +1 holds control and the buffer size, word +2 holds the buffer word address, and word +3 is a link word that this engine never reads. A flag in the control word marks the last descriptor of the ring; after that descriptor the engine returns to the ring base. A frame that finds no owned descriptor is dropped and counted. The memory port answers reads one cycle after the request and is never busy. The byte stream carries start, end and error markers, at one byte per cycle at most. Consecutive frames are separated by at least eight idle cycles.

Top module: `rx_ring_engine`

## Requirements
- R1: The engine reads only descriptor words +0, +1 and +2 of the descriptor at its current pointer (word addresses ptr, ptr+1, ptr+2). It never reads the link word or any buffer.
- R2: A frame is stored only into a descriptor whose status bit 31 (ownership) read as 1. The status write-back for that frame has bit 31 equal to 0.
- R3: When a frame starts and the current descriptor is not owned, or has not yet been fetched, the frame is dropped. No memory write occurs, missed_count increases by exactly 1, and the pointer does not move.
- R4: Byte k of a frame is written to word buf+k/4, in byte lane k%4 (bits 8*(k%4)+7 down to 8*(k%4)). Only lanes holding frame bytes are enabled through mem_be, so the other bytes of a partly filled word are left untouched.
- R5: Control bits 10:0 give the buffer size in bytes. Bytes with index at or above the size are not written, and the frame's error summary is set.
- R6: The written-back status word has bit 8 set (last descriptor of frame) and bit 15 set when the error input was seen on any byte of the frame or when bytes overflowed the buffer. Bits 30:16 hold the total byte count received, including trailing CRC bytes. All other bits are 0.
- R7: The status write occurs exactly two cycles after the cycle that carries the end-of-frame byte. It comes after every data write of that frame.
- R8: After a descriptor is completed, the pointer moves to ptr+4. When control bit 25 (end of ring) of that descriptor is set, the pointer returns to ring_base instead.
- R9: Reception runs only while op_mode bit 1 is set, and the other op_mode bits have no effect. While bit 1 is clear, the engine makes no memory access, and frames are neither stored nor counted. When bit 1 becomes set, the pointer is reloaded from ring_base.
- R10: After reset, missed_count is 0 and the memory port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 32 | Mode word; bit 1 enables reception |
| ring_base | input | AW | Word address of the first descriptor |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame error marker, with any byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| missed_count | output | CW | Frames dropped for lack of an owned descriptor |

## Verification
Each byte takes effect at the first clock edge after it is driven. A data write appears in the cycle after the byte that fills its word, or after the end-of-frame byte. The status write appears two cycles after the end-of-frame cycle. The frame driver records the cycle of each end-of-frame byte and queues the expected status address, value and due cycle. The monitor samples the memory port at the falling edge, pops the queue on every descriptor-region write, and compares the write's cycle with the due cycle. Buffer contents, missed_count and write counts are checked in the idle gap after a frame, once the status write is due to have happened.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    // Descriptor word offsets (word addresses relative to the descriptor)
    localparam int DESC_WORDS = 4;
    localparam int OFS_STATUS = 0;
    localparam int OFS_CTRL   = 1;
    localparam int OFS_BUF    = 2;

    // Bit positions the host software decodes
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 25;
    localparam int ERRSUM_BIT = 15;
    localparam int LAST_BIT   = 8;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 15;
    localparam int SIZE_W     = 11;
    localparam int RUN_BIT    = 1;

    typedef enum logic [3:0] {
        ST_OFF    = 4'd0,
        ST_POLL0  = 4'd1,
        ST_POLL1  = 4'd2,
        ST_POLL2  = 4'd3,
        ST_POLL3  = 4'd4,
        ST_FRAME  = 4'd5,
        ST_DROP   = 4'd6,
        ST_FLUSH  = 4'd7,
        ST_STATUS = 4'd8
    } state_e;

    function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len, input logic es);
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[ERRSUM_BIT]       = es;
        w[LAST_BIT]         = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW     = 16,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic          wrap_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] ptr_o
);

    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = base_i;
        end else if (adv_i) begin
            ptr_d = wrap_i ? base_i : ptr_q + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
    parameter int IW = 16,
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_en_i,
    input  logic [7:0]    byte_i,
    input  logic [IW-1:0] idx_i,
    input  logic [SW-1:0] size_i,
    input  logic          last_i,
    output logic          pend_o,
    output logic [31:0]   data_o,
    output logic [3:0]    be_o,
    output logic [IW-3:0] widx_o
);

    typedef struct packed {
        logic [31:0]   acc;
        logic [3:0]    acc_be;
        logic          pend;
        logic [31:0]   data;
        logic [3:0]    be;
        logic [IW-3:0] widx;
    } pack_t;

    pack_t d, q;

    logic [1:0]  lane;
    logic        keep;
    logic [31:0] acc_n;
    logic [3:0]  be_n;

    always_comb begin
        d     = q;
        d.pend = 1'b0;
        lane  = idx_i[1:0];
        keep  = idx_i < IW'(size_i);
        acc_n = (lane == 2'd0) ? 32'd0 : q.acc;
        be_n  = (lane == 2'd0) ? 4'd0  : q.acc_be;
        acc_n[{lane, 3'b000} +: 8] = byte_i;
        if (keep) be_n[lane] = 1'b1;
        if (byte_en_i) begin
            d.acc    = acc_n;
            d.acc_be = be_n;
            if (lane == 2'd3 || last_i) begin
                d.pend = |be_n;
                d.data = acc_n;
                d.be   = be_n;
                d.widx = idx_i[IW-1:2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;
    assign data_o = q.data;
    assign be_o   = q.be;
    assign widx_o = q.widx;

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   op_mode,
    input  logic [AW-1:0] ring_base,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_err,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [CW-1:0] missed_count
);

    typedef struct packed {
        state_e          st;
        logic            tmp_own;
        logic            tmp_eor;
        logic [SIZE_W-1:0] tmp_size;
        logic            c_valid;
        logic            c_own;
        logic            c_eor;
        logic [SIZE_W-1:0] c_size;
        logic [AW-1:0]   c_buf;
        logic [IW-1:0]   cnt;
        logic            ovf;
        logic            err;
        logic [CW-1:0]   missed;
    } regs_t;

    regs_t d, q;

    logic          run;
    logic          ptr_load, ptr_adv;
    logic [AW-1:0] ptr_q;
    logic          take_byte;
    logic [IW-1:0] byte_idx;
    logic          ovf_now;
    logic          wr_pend;
    logic [31:0]   wr_data;
    logic [3:0]    wr_be;
    logic [IW-3:0] wr_widx;
    state_e        cur_st;
    logic          unused_ok;

    assign run       = op_mode[RUN_BIT];
    assign cur_st    = q.st;
    assign unused_ok = ^{op_mode, mem_rdata};

    rxr_ring_ptr #(.AW(AW), .STRIDE(DESC_WORDS)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load),
        .adv_i  (ptr_adv),
        .wrap_i (q.c_eor),
        .base_i (ring_base),
        .ptr_o  (ptr_q)
    );

    rxr_packer #(.IW(IW), .SW(SIZE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_en_i (take_byte),
        .byte_i    (rx_data),
        .idx_i     (byte_idx),
        .size_i    (q.c_size),
        .last_i    (rx_eof),
        .pend_o    (wr_pend),
        .data_o    (wr_data),
        .be_o      (wr_be),
        .widx_o    (wr_widx)
    );

    // Next-state computation
    always_comb begin
        d         = q;
        ptr_load  = 1'b0;
        ptr_adv   = 1'b0;
        take_byte = 1'b0;
        byte_idx  = q.cnt;
        if (q.st == ST_POLL0 || q.st == ST_POLL1 || q.st == ST_POLL2 || q.st == ST_POLL3)
            byte_idx = '0;
        ovf_now = byte_idx >= IW'(q.c_size);

        unique case (q.st)
            ST_OFF: begin
                if (run) begin
                    ptr_load  = 1'b1;
                    d.c_valid = 1'b0;
                    d.st      = ST_POLL0;
                end
            end
            ST_POLL0, ST_POLL1, ST_POLL2, ST_POLL3: begin
                if (rx_valid && rx_sof) begin
                    if (q.c_valid && q.c_own) begin
                        take_byte = 1'b1;
                        d.cnt     = IW'(1);
                        d.ovf     = ovf_now;
                        d.err     = rx_err;
                        d.st      = rx_eof ? ST_FLUSH : ST_FRAME;
                    end else begin
                        d.missed  = q.missed + CW'(1);
                        d.st      = rx_eof ? ST_POLL0 : ST_DROP;
                    end
                end else if (!run) begin
                    d.st = ST_OFF;
                end else begin
                    unique case (q.st)
                        ST_POLL0: d.st = ST_POLL1;
                        ST_POLL1: begin
                            d.tmp_own = mem_rdata[OWN_BIT];
                            d.st      = ST_POLL2;
                        end
                        ST_POLL2: begin
                            d.tmp_eor  = mem_rdata[EOR_BIT];
                            d.tmp_size = mem_rdata[SIZE_W-1:0];
                            d.st       = ST_POLL3;
                        end
                        default: begin
                            d.c_valid = 1'b1;
                            d.c_own   = q.tmp_own;
                            d.c_eor   = q.tmp_eor;
                            d.c_size  = q.tmp_size;
                            d.c_buf   = mem_rdata[AW-1:0];
                            d.st      = ST_POLL0;
                        end
                    endcase
                end
            end
            ST_FRAME: begin
                if (rx_valid) begin
                    take_byte = 1'b1;
                    d.cnt     = q.cnt + IW'(1);
                    if (ovf_now) d.ovf = 1'b1;
                    if (rx_err)  d.err = 1'b1;
                    if (rx_eof)  d.st  = ST_FLUSH;
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_eof) d.st = ST_POLL0;
            end
            ST_FLUSH: d.st = ST_STATUS;
            ST_STATUS: begin
                ptr_adv   = 1'b1;
                d.c_valid = 1'b0;
                d.st      = ST_POLL0;
            end
            default: d.st = ST_OFF;
        endcase
    end

    // Memory port
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_be    = 4'd0;
        mem_wdata = '0;
        unique case (q.st)
            ST_POLL0: begin mem_en = 1'b1; mem_addr = ptr_q + AW'(OFS_STATUS); end
            ST_POLL1: begin mem_en = 1'b1; mem_addr = ptr_q + AW'(OFS_CTRL);   end
            ST_POLL2: begin mem_en = 1'b1; mem_addr = ptr_q + AW'(OFS_BUF);    end
            ST_FRAME, ST_FLUSH: begin
                if (wr_pend) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = q.c_buf + AW'(wr_widx);
                    mem_be    = wr_be;
                    mem_wdata = wr_data;
                end
            end
            ST_STATUS: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + AW'(OFS_STATUS);
                mem_be    = 4'hF;
                mem_wdata = pack_status(q.cnt[LEN_W-1:0], q.ovf | q.err);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign missed_count = q.missed;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic [CW-1:0] missed_count,
    input logic [AW-1:0] ptr,
    input state_e        cur_st
);

    logic unused_ok;
    assign unused_ok = ^mem_wdata;

    // R1
    desc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (AW'(mem_addr - ptr) < AW'(3)));

    // R2
    own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_STATUS) |-> (mem_en && mem_we && mem_addr == ptr
                                   && !mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT]));

    // R3
    missed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (missed_count == $past(missed_count)
                  || missed_count == $past(missed_count) + CW'(1)));

    // R4
    lane_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_be != 4'd0));

    // R7
    status_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_STATUS) |-> ($past(cur_st) == ST_FLUSH));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_OFF) |-> !mem_en);

endmodule

bind rx_ring_engine rxr_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .missed_count (missed_count),
    .ptr          (ptr_q),
    .cur_st       (cur_st)
);

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;

    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   op_mode = '0;
    logic [AW-1:0] ring_base = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_sof = 1'b0;
    logic          rx_eof = 1'b0;
    logic          rx_err = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic [CW-1:0] missed_count;

    always #10 clk = ~clk;

    rx_ring_engine #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .ring_base(ring_base),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .missed_count(missed_count)
    );

    // Memory model: one-cycle read latency, byte-lane writes
    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr[9:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;
    int wr_cnt = 0;
    int any_access = 0;
    int bad_reads = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] due;
    } exp_t;

    exp_t exp_q[$];

    // Monitor: descriptor-region writes are status write-backs
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            any_access++;
            if (mem_we) wr_cnt++;
            if (!mem_we && (mem_addr >= 16'd128 || mem_addr[1:0] == 2'd3)) bad_reads++;
            if (mem_we && mem_addr < 16'd128) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected status write", {16'd0, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(32'(mem_addr) == e.addr, "R8 status address", 32'(mem_addr), e.addr);
                    chk(mem_wdata == e.data, "R6 status word", mem_wdata, e.data);
                    chk(!mem_wdata[31], "R2 ownership returned", {31'd0, mem_wdata[31]}, 32'd0);
                    chk(32'(cyc) == e.due, "R7 status timing", 32'(cyc), e.due);
                end
            end
        end
    end

    function automatic logic [31:0] stat_word(input int len, input bit es);
        return (32'(len) << 16) | (es ? 32'h8000 : 32'h0) | 32'h100;
    endfunction

    task automatic arm(input int da, input int size, input bit eor, input int bufa);
        mem[da]   = 32'h8000_0000;
        mem[da+1] = (eor ? 32'h0200_0000 : 32'h0) | 32'(size);
        mem[da+2] = 32'(bufa);
        mem[da+3] = 32'hDEAD_0000;
        for (int w = 0; w < 16; w++) mem[bufa+w] = 32'hEEEE_EEEE;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: sends a frame, queues the expected status write-back
    task automatic send(input logic [7:0] seed, input int len, input bit err,
                        input int desc, input int size);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i * 3);
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_err   = err && (i == len - 1);
            if (i == len - 1 && desc >= 0) begin
                exp_t e;
                e.addr = 32'(desc);
                e.data = stat_word(len, err || (len > size));
                e.due  = 32'(cyc + 2);
                exp_q.push_back(e);
            end
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        idle(12);
    endtask

    task automatic check_buf(input int bufa, input logic [7:0] seed, input int len,
                             input int size, input string req);
        for (int w = 0; w < 4; w++) begin
            logic [31:0] e;
            for (int l = 0; l < 4; l++) begin
                int k = w * 4 + l;
                e[l*8 +: 8] = (k < len && k < size) ? seed + 8'(k * 3) : 8'hEE;
            end
            chk(mem[bufa+w] == e, req, mem[bufa+w], e);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        int w0, a0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        ring_base = 16'd16;
        arm(16, 64, 1'b0, 256);
        arm(20, 64, 1'b0, 272);
        arm(24, 8,  1'b1, 288);
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(missed_count == 0, "R10 missed after reset", 32'(missed_count), 32'd0);
        chk(!mem_en, "R10 port idle after reset", {31'd0, mem_en}, 32'd0);

        // R9: run bit clear, all other mode bits set -> no access
        op_mode = 32'hFFFF_FFFD;
        a0 = any_access;
        idle(8);
        chk(any_access == a0, "R9 no access with run clear", 32'(any_access - a0), 32'd0);

        op_mode = 32'h0000_0002;
        idle(10);

        // R4 R6: plain frame into descriptor 0
        send(8'h10, 6, 1'b0, 16, 64);
        check_buf(256, 8'h10, 6, 64, "R4 buffer of frame 1");

        // R6 R8: error-marked frame into descriptor 1 (pointer +4)
        send(8'h40, 8, 1'b1, 20, 64);
        check_buf(272, 8'h40, 8, 64, "R4 buffer of frame 2");

        // R5: 11 bytes into an 8-byte buffer, last descriptor of ring
        send(8'h80, 11, 1'b0, 24, 8);
        check_buf(288, 8'h80, 11, 8, "R5 overflow bytes not written");

        // R3: descriptor 0 now host-owned -> dropped
        w0 = wr_cnt;
        send(8'h20, 5, 1'b0, -1, 64);
        chk(missed_count == 1, "R3 missed count", 32'(missed_count), 32'd1);
        chk(wr_cnt == w0, "R3 no writes for dropped frame", 32'(wr_cnt - w0), 32'd0);

        // R8: re-arm descriptor 0; ring wrapped back to base
        arm(16, 64, 1'b0, 256);
        idle(10);
        send(8'h33, 1, 1'b0, 16, 64);
        chk(mem[256] == 32'hEEEE_EE33, "R4 single byte lane 0", mem[256], 32'hEEEE_EE33);
        chk(mem[257] == 32'hEEEE_EEEE, "R4 next word untouched", mem[257], 32'hEEEE_EEEE);

        // R9: stopped -> frame ignored, not counted
        op_mode = 32'h0;
        idle(3);
        w0 = wr_cnt;
        a0 = any_access;
        send(8'h77, 4, 1'b0, -1, 64);
        chk(any_access == a0, "R9 no access while stopped", 32'(any_access - a0), 32'd0);
        chk(missed_count == 1, "R9 stopped frame not counted", 32'(missed_count), 32'd1);

        // R9: restart reloads pointer from the new ring base
        ring_base = 16'd64;
        arm(64, 64, 1'b1, 320);
        op_mode = 32'h0000_0002;
        idle(10);
        send(8'h5A, 9, 1'b0, 64, 64);
        check_buf(320, 8'h5A, 9, 64, "R9 frame after restart");

        chk(exp_q.size() == 0, "R7 all status writes seen", 32'(exp_q.size()), 32'd0);
        chk(bad_reads == 0, "R1 reads only descriptor words", 32'(bad_reads), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule